// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler with Deferral

This block keeps a two-rank DDR SDRAM refreshed. An interval timer counts down from a programmable interval register. Each time it expires, it adds one refresh to a small pending count. A pending refresh waits until no data transfer is in flight and no locked multi-transaction tenure is held. The block then plays out a fixed command sequence:

1. A precharge-all to the populated ranks, together with a pulse that invalidates every open-page tracking entry.
2. A programmable tRP gap.
3. An auto-refresh strobe to rank 0 and, in the following cycle, to rank 1.
4. A tRFC recovery window.

The memory arbiter watches the busy output and holds off new work for the whole sequence. The pending count holds two refreshes, because a worst-case locked tenure can cover two refresh intervals. A third expiry while two are pending saturates the count and sets a sticky overflow flag. Address generation and the data path live elsewhere.

Top module: `ddr_refresh_sched`

## Requirements
- R1: The interval timer expires once every N cycles, where N is the interval register (a value of 0 acts as 1). Counting from the first cycle after reset release as cycle 0, the first expiry is in cycle N-1. A register write takes effect at the next reload. The timer keeps running while refreshes are pending or a sequence is active.
- R2: A sequence is started in a cycle where the block is idle, the pending count is non-zero, and both `xfer_busy_i` and `locked_i` are low. Its precharge slot is the following cycle. It never starts while either input is high.
- R3: In the precharge slot, `pre_all_o` is high for exactly one cycle if any rank is populated.
- R4: `page_clr_o` is high in the precharge slot, and only there, whether or not any rank is populated.
- R5: Auto-refresh to rank 0 (`aref_o[0]`) comes TRP_CYC+1 cycles after the precharge slot. Auto-refresh to rank 1 (`aref_o[1]`) comes in the next cycle. At most one bit of `aref_o` is high at a time.
- R6: `ref_busy_o` is high from the precharge slot through TRFC_CYC cycles after the last auto-refresh slot, that is for 1+TRP_CYC+2+TRFC_CYC cycles.
- R7: `pend_cnt_o` ranges from 0 to 2. It rises by one on an expiry and falls by one when a sequence starts. It is unchanged when both happen in the same cycle.
- R8: Reset is synchronous and active low. After reset, every strobe and `ref_busy_o` are low, `pend_cnt_o` is 0, `ovf_o` is 0, and the interval register holds DEF_INTERVAL. DEF_INTERVAL defaults to 0x618; the package also gives 0xC30, 0x820 and 0x1040 as alternative reset values.
- R9: `rank_pop_i[r]` gates the strobe `aref_o[r]`, and `|rank_pop_i` gates `pre_all_o`. The slot of an unpopulated rank is still spent, so the timing is unchanged.
- R10: An expiry while the count is already 2, with no sequence starting in that cycle, leaves the count at 2 and sets `ovf_o`. `ovf_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_wr_i | input | 1 | write strobe for the interval register |
| cfg_interval_i | input | IW | new interval value |
| rank_pop_i | input | NUM_RANKS | populated-rank mask |
| xfer_busy_i | input | 1 | a data transfer is in progress |
| locked_i | input | 1 | a locked tenure is held |
| pre_all_o | output | 1 | precharge-all strobe |
| page_clr_o | output | 1 | invalidate all open-page entries |
| aref_o | output | NUM_RANKS | per-rank auto-refresh strobes |
| ref_busy_o | output | 1 | refresh sequence active, hold off new requests |
| pend_cnt_o | output | PW | number of refreshes waiting |
| ovf_o | output | 1 | sticky: a refresh was lost |

## Verification
The bench builds the block with a reset interval of 40, TRP_CYC of 2 and TRFC_CYC of 6. A full sequence then lasts 11 cycles, so many expiries fit in a run of about a thousand cycles. A locked tenure of 130 cycles spans three expiries, which reaches saturation and overflow. Later writes of intervals 12 and 5 place expiries inside an active sequence and let expiry and start fall in the same cycle.

// File: rtl/ddr_ref_pkg.sv
// Shared types and typical interval constants for the refresh scheduler.
package ddr_ref_pkg;
    // Sequencer states.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_TRP,
        SQ_AREF,
        SQ_TRFC
    } seq_state_e;

    // Typical interval values: about 7.8 us and 15.6 us at two data rates.
    localparam logic [15:0] INTV_400_7P8  = 16'h0618;
    localparam logic [15:0] INTV_400_15P6 = 16'h0C30;
    localparam logic [15:0] INTV_533_7P8  = 16'h0820;
    localparam logic [15:0] INTV_533_15P6 = 16'h1040;
endpackage

// File: rtl/ref_interval_timer.sv
// Interval timer: holds the programmable interval register and counts down.
// Gives a one-cycle expiry when the count reaches 1, then reloads.
// Assumes: a write changes only the register; the running count finishes
// its current period first. An interval of 0 is treated as 1.
module ref_interval_timer #(
    parameter int unsigned   IW      = 16,
    parameter logic [IW-1:0] DEF_VAL = IW'(ddr_ref_pkg::INTV_400_7P8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_i,
    input  logic [IW-1:0] cfg_val_i,
    output logic          expire_o
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] ireg_q;
    logic [IW-1:0] cnt_q;
    logic [IW-1:0] reload;

    // Interval register, written by configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)        ireg_q <= DEF_VAL;
        else if (cfg_wr_i) ireg_q <= cfg_val_i;
    end

    // Reload value with zero clamped to one.
    always_comb reload = (ireg_q == '0) ? ONE : ireg_q;

    // Expiry when the count has reached its last cycle.
    always_comb expire_o = (cnt_q <= ONE);

    // Down counter, reloaded on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= DEF_VAL;
        else if (expire_o) cnt_q <= reload;
        else               cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/ref_pend_ctr.sv
// Pending-refresh counter: saturates at PEND_MAX and keeps a sticky
// overflow flag for expiries that could not be queued.
// Assumes: dec_i is only asserted while the count is non-zero.
module ref_pend_ctr #(
    parameter int unsigned PEND_MAX = 2,
    parameter int unsigned PW       = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [PW-1:0] cnt_o,
    output logic          nz_o,
    output logic          ovf_o
);
    localparam logic [PW-1:0] CMAX = PW'(PEND_MAX);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] cnt_q;
    logic          ovf_q;

    // Count update: add on expiry, subtract on start, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            case ({inc_i, dec_i})
                2'b10: begin
                    if (cnt_q == CMAX) ovf_q <= 1'b1;
                    else               cnt_q <= cnt_q + ONE;
                end
                2'b01: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - ONE;
                end
                default: ;
            endcase
        end
    end

    // Outputs straight from the state.
    always_comb begin
        cnt_o = cnt_q;
        nz_o  = (cnt_q != '0);
        ovf_o = ovf_q;
    end
endmodule

// File: rtl/ref_cmd_seq.sv
// Refresh command sequencer. Order of a sequence:
//   precharge-all with page-clear -> tRP wait -> one auto-refresh slot per rank -> tRFC wait.
// Assumes: rank slots are consecutive cycles, and an unpopulated rank keeps its slot.
module ref_cmd_seq
    import ddr_ref_pkg::*;
#(
    parameter int unsigned NUM_RANKS = 2,
    parameter int unsigned TRP_CYC   = 2,
    parameter int unsigned TRFC_CYC  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pend_nz_i,
    input  logic                 xfer_busy_i,
    input  logic                 locked_i,
    input  logic [NUM_RANKS-1:0] rank_pop_i,
    output logic                 start_o,
    output logic                 pre_all_o,
    output logic                 page_clr_o,
    output logic [NUM_RANKS-1:0] aref_o,
    output logic                 busy_o
);
    localparam int unsigned WMAX = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int unsigned WW   = $clog2(WMAX + 2);
    localparam int unsigned RW   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
    localparam logic [WW-1:0] W_ONE = WW'(1);
    localparam logic [RW-1:0] LAST_RANK = RW'(NUM_RANKS - 1);

    seq_state_e    state_q, state_d;
    logic [WW-1:0] wcnt_q, wcnt_d;
    logic [RW-1:0] rank_q, rank_d;

    // Start decision: idle, work pending, and no transfer or tenure in the way.
    always_comb start_o = (state_q == SQ_IDLE) && pend_nz_i && !xfer_busy_i && !locked_i;

    // Next-state logic for the sequence.
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        rank_d  = rank_q;
        case (state_q)
            SQ_IDLE: begin
                if (start_o) state_d = SQ_PRE;
            end
            SQ_PRE: begin
                rank_d = '0;
                if (TRP_CYC == 0) begin
                    state_d = SQ_AREF;
                end else begin
                    state_d = SQ_TRP;
                    wcnt_d  = WW'(TRP_CYC);
                end
            end
            SQ_TRP: begin
                if (wcnt_q <= W_ONE) state_d = SQ_AREF;
                else                 wcnt_d  = wcnt_q - W_ONE;
            end
            SQ_AREF: begin
                if (rank_q == LAST_RANK) begin
                    if (TRFC_CYC == 0) begin
                        state_d = SQ_IDLE;
                    end else begin
                        state_d = SQ_TRFC;
                        wcnt_d  = WW'(TRFC_CYC);
                    end
                end else begin
                    rank_d = rank_q + RW'(1);
                end
            end
            SQ_TRFC: begin
                if (wcnt_q <= W_ONE) state_d = SQ_IDLE;
                else                 wcnt_d  = wcnt_q - W_ONE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            wcnt_q  <= '0;
            rank_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            rank_q  <= rank_d;
        end
    end

    // Precharge slot outputs and the busy window.
    always_comb begin
        pre_all_o  = (state_q == SQ_PRE) && (|rank_pop_i);
        page_clr_o = (state_q == SQ_PRE);
        busy_o     = (state_q != SQ_IDLE);
    end

    // One auto-refresh strobe per rank, gated by the populated mask.
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        assign aref_o[r] = (state_q == SQ_AREF) && (rank_q == RW'(r)) && rank_pop_i[r];
    end
endmodule

// File: rtl/ddr_refresh_sched.sv
// Top of the refresh scheduler. The interval timer feeds the pending
// counter, which releases sequences through the command sequencer.
// Assumes: the arbiter honours ref_busy_o, and the inputs are synchronous to clk.
module ddr_refresh_sched #(
    parameter int unsigned   IW           = 16,
    parameter logic [IW-1:0] DEF_INTERVAL = IW'(ddr_ref_pkg::INTV_400_7P8),
    parameter int unsigned   NUM_RANKS    = 2,
    parameter int unsigned   PEND_MAX     = 2,
    parameter int unsigned   TRP_CYC      = 2,
    parameter int unsigned   TRFC_CYC     = 8,
    parameter int unsigned   PW           = $clog2(PEND_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_i,
    input  logic [IW-1:0]        cfg_interval_i,
    input  logic [NUM_RANKS-1:0] rank_pop_i,
    input  logic                 xfer_busy_i,
    input  logic                 locked_i,
    output logic                 pre_all_o,
    output logic                 page_clr_o,
    output logic [NUM_RANKS-1:0] aref_o,
    output logic                 ref_busy_o,
    output logic [PW-1:0]        pend_cnt_o,
    output logic                 ovf_o
);
    logic expire;
    logic start;
    logic pend_nz;

    ref_interval_timer #(.IW(IW), .DEF_VAL(DEF_INTERVAL)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr_i (cfg_wr_i),
        .cfg_val_i(cfg_interval_i),
        .expire_o (expire)
    );

    ref_pend_ctr #(.PEND_MAX(PEND_MAX), .PW(PW)) i_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i(expire),
        .dec_i(start),
        .cnt_o(pend_cnt_o),
        .nz_o (pend_nz),
        .ovf_o(ovf_o)
    );

    ref_cmd_seq #(.NUM_RANKS(NUM_RANKS), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_nz_i  (pend_nz),
        .xfer_busy_i(xfer_busy_i),
        .locked_i   (locked_i),
        .rank_pop_i (rank_pop_i),
        .start_o    (start),
        .pre_all_o  (pre_all_o),
        .page_clr_o (page_clr_o),
        .aref_o     (aref_o),
        .busy_o     (ref_busy_o)
    );
endmodule

// File: rtl/refresh_sched_chk.sv
// Property checker for ddr_refresh_sched, attached with bind below.
module refresh_sched_chk #(
    parameter int unsigned NUM_RANKS = 2,
    parameter int unsigned PEND_MAX  = 2,
    parameter int unsigned PW        = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 xfer_busy_i,
    input logic                 locked_i,
    input logic [NUM_RANKS-1:0] rank_pop_i,
    input logic                 pre_all_o,
    input logic                 page_clr_o,
    input logic [NUM_RANKS-1:0] aref_o,
    input logic                 ref_busy_o,
    input logic [PW-1:0]        pend_cnt_o,
    input logic                 ovf_o
);
    // R2
    no_start_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy_o) |-> (!$past(xfer_busy_i) && !$past(locked_i) && ($past(pend_cnt_o) != '0)));
    // R3
    seq_opens_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy_o) |-> page_clr_o);
    // R4
    pre_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_o |-> page_clr_o);
    // R6
    clear_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_clr_o |-> ref_busy_o);
    // R5
    aref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(aref_o));
    // R9
    aref_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aref_o & ~rank_pop_i) == '0);
    // R7
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt_o <= PW'(PEND_MAX));
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

bind ddr_refresh_sched refresh_sched_chk #(
    .NUM_RANKS(NUM_RANKS),
    .PEND_MAX (PEND_MAX),
    .PW       (PW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_busy_i(xfer_busy_i),
    .locked_i   (locked_i),
    .rank_pop_i (rank_pop_i),
    .pre_all_o  (pre_all_o),
    .page_clr_o (page_clr_o),
    .aref_o     (aref_o),
    .ref_busy_o (ref_busy_o),
    .pend_cnt_o (pend_cnt_o),
    .ovf_o      (ovf_o)
);

// File: tb/test_ddr_refresh_sched.sv
// Bench with a behavioural reference model compared on every clock.
module test_ddr_refresh_sched;
    localparam int IV   = 40;
    localparam int TRP  = 2;
    localparam int TRFC = 6;
    localparam int NR   = 2;
    localparam int LAST = TRP + NR + TRFC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [15:0]   cfg_val = '0;
    logic [NR-1:0] pop = 2'b11;
    logic          xfer = 1'b0;
    logic          lock = 1'b0;
    logic          pre, clr, busy, ovf;
    logic [NR-1:0] aref;
    logic [1:0]    pend;

    int n_chk = 0;
    int n_bad = 0;
    bit armed = 0;
    int ncyc = 0;
    int first_pre = -1;

    // model state
    int m_rem = IV, m_ireg = IV, m_pend = 0, m_seq = -1;
    bit m_ovf = 0;

    always #5 clk = ~clk;

    ddr_refresh_sched #(
        .IW(16), .DEF_INTERVAL(16'(IV)), .NUM_RANKS(NR), .PEND_MAX(2),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC)
    ) i_ddr_refresh_sched (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_interval_i(cfg_val),
        .rank_pop_i(pop), .xfer_busy_i(xfer), .locked_i(lock),
        .pre_all_o(pre), .page_clr_o(clr), .aref_o(aref), .ref_busy_o(busy),
        .pend_cnt_o(pend), .ovf_o(ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model step on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = IV; m_ireg = IV; m_pend = 0; m_ovf = 0; m_seq = -1; ncyc = 0;
        end else begin
            bit ex, st;
            ncyc++;
            ex = (m_rem <= 1);
            st = (m_seq < 0) && (m_pend > 0) && !xfer && !lock;
            if (m_seq >= 0) m_seq = (m_seq == LAST) ? -1 : m_seq + 1;
            else if (st)    m_seq = 0;
            if (ex && !st) begin
                if (m_pend == 2) m_ovf = 1; else m_pend++;
            end else if (st && !ex) m_pend--;
            if (ex) m_rem = (m_ireg == 0) ? 1 : m_ireg;
            else    m_rem--;
            if (cfg_wr) m_ireg = int'(cfg_val);
        end
    end

    // Compare outputs with the model mid-cycle.
    always @(negedge clk) begin
        if (armed) begin
            bit e_pre, e_clr, e_busy;
            logic [NR-1:0] e_aref;
            e_clr  = (m_seq == 0);
            e_pre  = e_clr && (|pop);
            e_busy = (m_seq >= 0);
            for (int r = 0; r < NR; r++) e_aref[r] = (m_seq == TRP + 1 + r) && pop[r];
            chk(pre == e_pre, "R3 pre_all", int'(pre), int'(e_pre));
            chk(clr == e_clr, "R4 page_clr", int'(clr), int'(e_clr));
            chk(aref == e_aref, "R5/R9 aref", int'(aref), int'(e_aref));
            chk(busy == e_busy, "R6 busy", int'(busy), int'(e_busy));
            chk(int'(pend) == m_pend, "R7 pend", int'(pend), m_pend);
            chk(ovf == m_ovf, "R10 ovf", int'(ovf), int'(m_ovf));
            if (pre && first_pre < 0) first_pre = ncyc;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        cyc(3);
        armed = 1;
        @(negedge clk);
        // R8: idle state during reset
        chk(!pre && !clr && aref == '0 && !busy && pend == 0 && !ovf, "R8 reset outputs",
            int'({pre, clr, aref, busy, pend, ovf}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        cyc(100);
        // R8/R1: first refresh precharge one cycle after pending becomes visible at cycle IV
        chk(first_pre == IV + 1, "R8 R1 first precharge cycle", first_pre, IV + 1);
        // R2: transfer pattern defers starts
        for (int i = 0; i < 200; i++) begin
            xfer = (i % 7) < 3;
            cyc(1);
        end
        xfer = 1'b0;
        // R7 R10: long locked tenure spans three expiries
        lock = 1'b1;
        cyc(130);
        @(negedge clk);
        chk(pend == 2, "R7 saturated count", int'(pend), 2);
        chk(ovf == 1'b1, "R10 overflow set", int'(ovf), 1);
        @(posedge clk); #1 lock = 1'b0;
        cyc(60);
        // R9: rank masks
        pop = 2'b01; cyc(90);
        pop = 2'b10; cyc(90);
        pop = 2'b00; cyc(90);
        pop = 2'b11;
        // R1: shorter intervals
        cfg_val = 16'd12; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
        cyc(200);
        cfg_val = 16'd5; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
        for (int i = 0; i < 80; i++) begin
            lock = (i % 11) < 2;
            cyc(1);
        end
        lock = 1'b0;
        cfg_val = 16'd0; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
        cyc(40);
        // R10: reset clears sticky overflow
        rst_n = 1'b0; cyc(2);
        @(negedge clk);
        chk(ovf == 1'b0 && pend == 0, "R10 R8 cleared by reset", int'({ovf, pend}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        cyc(60);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(1_000_000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule